// File: doc/BRIEF.md
# DDR2 Command and Power-Up Sequencer

This block sits on the controller side of a DDR2 SDRAM interface and turns simple requests into command-pin activity. A requester presents an operation (mode load, activate, read, write, precharge, refresh, power-down, self-refresh or idle) together with a bank, a row or mode value, a column and a single flag bit. The handshake is ready/valid. The block registers the matching clock-enable, chip-select, row-strobe, column-strobe, write-enable, bank and address values onto its outputs in the cycle after it accepts the request.

After reset it runs the power-up sequence by itself and refuses requests until that sequence ends. It keeps shadow copies of the mode-register and extended-mode-register fields, from which it reports read latency, write latency, burst length and burst order.

Minimum command spacings are given in nanoseconds. They become clock counts by dividing by the clock period and rounding up. Per-bank timers and one shared timer hold the ready signal low until the spacing that applies to the pending request has passed.

Top module: `ddr2_cmd_seq`

## Requirements
- R1: While rst_ni is low, cke_o is 0, the command pins {cs_no,ras_no,cas_no,we_no} read 1111 (deselect), req_ready_o is 0 and init_done_o is 0.
- R2: After reset release, cke_o stays low with deselect for CKE_LOW_CYC (10) cycles. It then goes high with NOP (0111) for INIT_C = ceil(INIT_NS / period) cycles, after which init_done_o rises and stays high.
- R3: No request is accepted before init_done_o is high, and the power-up pin pattern is not disturbed by a pending request.
- R4: Operation codes on req_op_i are 0 idle, 1 mode load, 2 activate, 3 read, 4 write, 5 precharge, 6 refresh, 7 power-down, 8 self-refresh. An accepted request shows on the pins one cycle later with command codes mode load 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, and cke_o high. Activate and mode load drive req_addr_i on a_o and the bank on ba_o.
- R5: For read and write, column bits [9:0] go to a_o[9:0], column bits from 10 upward go to a_o from bit 11 upward, and a_o[10] carries req_flag_i (auto-precharge).
- R6: Precharge drives a_o[10] = req_flag_i (1 closes all banks) with every other address bit 0, and drives the bank on ba_o.
- R7: A mode load to bank 0 captures CAS latency (value bits [6:4]), burst order (bit 3) and burst-length exponent (bits [2:0]). A mode load to bank 1 captures additive latency (bits [5:3]). rd_lat_o = AL+CL, wr_lat_o = AL+CL-1, burst_len_o = 2^exponent.
- R8: A mode load to a bank above 1 is issued on the pins but leaves every reported latency and burst field unchanged.
- R9: A read or write to a bank is issued no sooner than ceil(TRCD_NS/period) cycles after an activate to the same bank. Commands to a different bank are not delayed by it.
- R10: An activate to a bank is issued no sooner than ceil(TRP_NS/period) cycles after a precharge that covers that bank, either a single-bank or an all-bank precharge. Other banks are not delayed.
- R11: After a refresh, the next spaced command waits ceil(TRFC_NS/period) cycles. After a mode load it waits ceil(TMOD_NS/period) cycles.
- R12: An accepted power-down request drives cke_o low with deselect for that cycle. With no request, the next cycle returns to cke_o high with NOP.
- R13: Self-refresh entry drives cke_o low with the refresh code for one cycle. cke_o then stays low with deselect while no other request is valid. Any other valid request causes one exit cycle with cke_o high and NOP, and then waits ceil(TXSNR_NS/period) cycles counted from that exit cycle.
- R14: After initialization, with no request or with an undefined operation code (9 to 15), the pins show cke_o high, NOP, and zero on ba_o and a_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_op_i | input | 4 | Operation code |
| req_bank_i | input | BA_W | Target bank |
| req_addr_i | input | A_W | Row for activate, value for mode load |
| req_col_i | input | COL_W | Column for read and write |
| req_flag_i | input | 1 | Auto-precharge or precharge-all flag |
| init_done_o | output | 1 | Power-up sequence finished |
| cke_o | output | 1 | Clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| a_o | output | A_W | Multiplexed address |
| rd_lat_o | output | 4 | Read latency in cycles |
| wr_lat_o | output | 4 | Write latency in cycles |
| burst_len_o | output | 8 | Burst length |
| burst_order_o | output | 1 | Burst order bit |

## Verification
A vector table drives each command type with addresses whose bits differ across the column split and the A10 position. This separates a correct column placement from one that overlaps or drops the upper column bit, and a precharge-all from a single-bank precharge.

Directed back-to-back pairs measure the pin-to-pin gap for same-bank and different-bank sequences, and for refresh, mode-load and self-refresh exit. A timer that is off by one, shared across banks, or never loaded shows up as a wrong gap.

Mode loads to banks 0, 1 and 2 tell apart the two shadow registers and the ignored bank. Requests held during power-up show whether the power-up counts can be cut short.

// File: rtl/ddr2_seq_pkg.sv
package ddr2_seq_pkg;

  typedef enum logic [3:0] {
    OP_IDLE = 4'd0,
    OP_MRS  = 4'd1,
    OP_ACT  = 4'd2,
    OP_RD   = 4'd3,
    OP_WR   = 4'd4,
    OP_PRE  = 4'd5,
    OP_REF  = 4'd6,
    OP_PD   = 4'd7,
    OP_SR   = 4'd8
  } req_op_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111,
    CMD_DES = 4'b1111
  } cmd_e;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

endpackage

// File: rtl/ddr2_init_ctrl.sv
module ddr2_init_ctrl #(
  parameter int unsigned CKE_LOW_CYC = 10,
  parameter int unsigned INIT_C      = 40000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic cke_o,
  output logic done_o
);

  localparam int unsigned MAXC = (CKE_LOW_CYC > INIT_C) ? CKE_LOW_CYC : INIT_C;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic          nop_phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      nop_phase_q <= 1'b0;
      done_o      <= 1'b0;
    end else if (!done_o) begin
      if (!nop_phase_q) begin
        if (cnt_q == CW'(CKE_LOW_CYC - 1)) begin
          nop_phase_q <= 1'b1;
          cnt_q       <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (cnt_q == CW'(INIT_C - 1)) begin
        done_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cke_o = nop_phase_q;

endmodule

// File: rtl/ddr2_bank_timers.sv
module ddr2_bank_timers #(
  parameter int unsigned BA_W   = 2,
  parameter int unsigned NBANK  = 4,
  parameter int unsigned TRCD_C = 2,
  parameter int unsigned TRP_C  = 2,
  parameter int unsigned GW     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             pre_all_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic             glob_load_i,
  input  logic [GW-1:0]    glob_val_i,
  output logic [NBANK-1:0] rcd_busy_o,
  output logic [NBANK-1:0] rp_busy_o,
  output logic             glob_busy_o
);

  localparam int unsigned BMAX = (TRCD_C > TRP_C) ? TRCD_C : TRP_C;
  localparam int unsigned BW   = $clog2(BMAX + 1);

  // counters hold (spacing - 1) so the gap between commands on the pins equals the spacing
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [BW-1:0] rcd_q, rp_q;
    logic          hit;

    assign hit = (bank_i == BA_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rcd_q <= '0;
        rp_q  <= '0;
      end else begin
        if (act_i && hit)                  rcd_q <= BW'(TRCD_C - 1);
        else if (rcd_q != '0)              rcd_q <= rcd_q - 1'b1;
        if (pre_i && (pre_all_i || hit))   rp_q  <= BW'(TRP_C - 1);
        else if (rp_q != '0)               rp_q  <= rp_q - 1'b1;
      end
    end

    assign rcd_busy_o[b] = (rcd_q != '0);
    assign rp_busy_o[b]  = (rp_q != '0);
  end

  logic [GW-1:0] glob_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              glob_q <= '0;
    else if (glob_load_i)     glob_q <= glob_val_i;
    else if (glob_q != '0)    glob_q <= glob_q - 1'b1;
  end

  assign glob_busy_o = (glob_q != '0);

endmodule

// File: rtl/ddr2_cmd_enc.sv
module ddr2_cmd_enc
  import ddr2_seq_pkg::*;
#(
  parameter int unsigned BA_W  = 2,
  parameter int unsigned A_W   = 14,
  parameter int unsigned COL_W = 11
) (
  input  req_op_e          op_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic [A_W-1:0]   addr_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             flag_i,
  input  logic             sr_active_i,
  output cmd_e             cmd_o,
  output logic             cke_o,
  output logic [BA_W-1:0]  ba_o,
  output logic [A_W-1:0]   a_o
);

  logic [A_W-1:0] col_a;

  // column split around A10
  if (COL_W > 10) begin : g_wide_col
    assign col_a = A_W'({col_i[COL_W-1:10], flag_i, col_i[9:0]});
  end else begin : g_narrow_col
    assign col_a = A_W'({flag_i, 10'(col_i)});
  end

  always_comb begin
    cmd_o = CMD_NOP;
    cke_o = 1'b1;
    ba_o  = '0;
    a_o   = '0;
    case (op_i)
      OP_MRS: begin cmd_o = CMD_MRS; ba_o = bank_i; a_o = addr_i; end
      OP_ACT: begin cmd_o = CMD_ACT; ba_o = bank_i; a_o = addr_i; end
      OP_RD:  begin cmd_o = CMD_RD;  ba_o = bank_i; a_o = col_a;  end
      OP_WR:  begin cmd_o = CMD_WR;  ba_o = bank_i; a_o = col_a;  end
      OP_PRE: begin cmd_o = CMD_PRE; ba_o = bank_i; a_o[10] = flag_i; end
      OP_REF: cmd_o = CMD_REF;
      OP_PD:  begin cmd_o = CMD_DES; cke_o = 1'b0; end
      OP_SR:  begin cmd_o = sr_active_i ? CMD_DES : CMD_REF; cke_o = 1'b0; end
      default: cmd_o = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/ddr2_cmd_seq.sv
module ddr2_cmd_seq
  import ddr2_seq_pkg::*;
#(
  parameter int unsigned CLK_PS      = 10000,
  parameter int unsigned INIT_NS     = 400000,
  parameter int unsigned CKE_LOW_CYC = 10,
  parameter int unsigned TRCD_NS     = 15,
  parameter int unsigned TRP_NS      = 15,
  parameter int unsigned TRFC_NS     = 105,
  parameter int unsigned TMOD_NS     = 12,
  parameter int unsigned TXSNR_NS    = 115,
  parameter int unsigned BA_W        = 2,
  parameter int unsigned A_W         = 14,
  parameter int unsigned COL_W       = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [3:0]       req_op_i,
  input  logic [BA_W-1:0]  req_bank_i,
  input  logic [A_W-1:0]   req_addr_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic             req_flag_i,
  output logic             init_done_o,
  output logic             cke_o,
  output logic             cs_no,
  output logic             ras_no,
  output logic             cas_no,
  output logic             we_no,
  output logic [BA_W-1:0]  ba_o,
  output logic [A_W-1:0]   a_o,
  output logic [3:0]       rd_lat_o,
  output logic [3:0]       wr_lat_o,
  output logic [7:0]       burst_len_o,
  output logic             burst_order_o
);

  localparam int unsigned NBANK   = 1 << BA_W;
  localparam int unsigned INIT_C  = ns2cyc(INIT_NS, CLK_PS);
  localparam int unsigned TRCD_C  = ns2cyc(TRCD_NS, CLK_PS);
  localparam int unsigned TRP_C   = ns2cyc(TRP_NS, CLK_PS);
  localparam int unsigned TRFC_C  = ns2cyc(TRFC_NS, CLK_PS);
  localparam int unsigned TMOD_C  = ns2cyc(TMOD_NS, CLK_PS);
  localparam int unsigned TXSNR_C = ns2cyc(TXSNR_NS, CLK_PS);
  localparam int unsigned GMAX0   = (TRFC_C > TMOD_C) ? TRFC_C : TMOD_C;
  localparam int unsigned GMAX    = (GMAX0 > TXSNR_C) ? GMAX0 : TXSNR_C;
  localparam int unsigned GW      = $clog2(GMAX + 1);

  req_op_e          op;
  logic             init_cke;
  logic [NBANK-1:0] rcd_busy, rp_busy;
  logic             glob_busy;
  logic             cmd_ok, fire, sr_exit, sr_active_q;
  logic             glob_load;
  logic [GW-1:0]    glob_val;
  cmd_e             enc_cmd, cmd_q;
  logic             enc_cke, cke_q;
  logic [BA_W-1:0]  enc_ba, ba_q;
  logic [A_W-1:0]   enc_a, a_q;
  logic [2:0]       cl_q, bl_exp_q, al_q;
  logic             bo_q;
  logic [3:0]       rd_lat;

  assign op = req_op_e'(req_op_i);

  ddr2_init_ctrl #(
    .CKE_LOW_CYC(CKE_LOW_CYC),
    .INIT_C     (INIT_C)
  ) u_init (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cke_o (init_cke),
    .done_o(init_done_o)
  );

  ddr2_bank_timers #(
    .BA_W  (BA_W),
    .NBANK (NBANK),
    .TRCD_C(TRCD_C),
    .TRP_C (TRP_C),
    .GW    (GW)
  ) u_timers (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (fire && op == OP_ACT),
    .pre_i      (fire && op == OP_PRE),
    .pre_all_i  (req_flag_i),
    .bank_i     (req_bank_i),
    .glob_load_i(glob_load),
    .glob_val_i (glob_val),
    .rcd_busy_o (rcd_busy),
    .rp_busy_o  (rp_busy),
    .glob_busy_o(glob_busy)
  );

  ddr2_cmd_enc #(
    .BA_W (BA_W),
    .A_W  (A_W),
    .COL_W(COL_W)
  ) u_enc (
    .op_i       (op),
    .bank_i     (req_bank_i),
    .addr_i     (req_addr_i),
    .col_i      (req_col_i),
    .flag_i     (req_flag_i),
    .sr_active_i(sr_active_q),
    .cmd_o      (enc_cmd),
    .cke_o      (enc_cke),
    .ba_o       (enc_ba),
    .a_o        (enc_a)
  );

  always_comb begin
    case (op)
      OP_ACT:               cmd_ok = !rp_busy[req_bank_i] && !glob_busy;
      OP_RD, OP_WR:         cmd_ok = !rcd_busy[req_bank_i] && !glob_busy;
      OP_PRE, OP_PD:        cmd_ok = !glob_busy;
      OP_MRS, OP_REF, OP_SR: cmd_ok = !glob_busy && !(|rp_busy);
      default:              cmd_ok = 1'b1;
    endcase
  end

  assign req_ready_o = init_done_o && !(sr_active_q && op != OP_SR) && cmd_ok;
  assign fire        = req_valid_i && req_ready_o;
  assign sr_exit     = init_done_o && sr_active_q && req_valid_i && op != OP_SR;
  assign glob_load   = sr_exit || (fire && (op == OP_REF || op == OP_MRS));
  assign glob_val    = sr_exit ? GW'(TXSNR_C - 1) :
                       (op == OP_REF) ? GW'(TRFC_C - 1) : GW'(TMOD_C - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q       <= 1'b1;
      cmd_q       <= CMD_NOP;
      ba_q        <= '0;
      a_q         <= '0;
      sr_active_q <= 1'b0;
      cl_q        <= '0;
      bo_q        <= 1'b0;
      bl_exp_q    <= '0;
      al_q        <= '0;
    end else if (init_done_o) begin
      if (fire) begin
        cke_q <= enc_cke;
        cmd_q <= enc_cmd;
        ba_q  <= enc_ba;
        a_q   <= enc_a;
      end else begin
        cke_q <= !(sr_active_q && !sr_exit);
        cmd_q <= (sr_active_q && !sr_exit) ? CMD_DES : CMD_NOP;
        ba_q  <= '0;
        a_q   <= '0;
      end
      if (fire && op == OP_SR) sr_active_q <= 1'b1;
      else if (sr_exit)        sr_active_q <= 1'b0;
      if (fire && op == OP_MRS && req_bank_i == BA_W'(0)) begin
        cl_q     <= req_addr_i[6:4];
        bo_q     <= req_addr_i[3];
        bl_exp_q <= req_addr_i[2:0];
      end
      if (fire && op == OP_MRS && req_bank_i == BA_W'(1)) al_q <= req_addr_i[5:3];
    end
  end

  assign cke_o = init_done_o ? cke_q : init_cke;
  assign {cs_no, ras_no, cas_no, we_no} = init_done_o ? cmd_q : (init_cke ? CMD_NOP : CMD_DES);
  assign ba_o  = ba_q;
  assign a_o   = a_q;

  assign rd_lat        = 4'(al_q) + 4'(cl_q);
  assign rd_lat_o      = rd_lat;
  assign wr_lat_o      = rd_lat - 4'd1;
  assign burst_len_o   = 8'd1 << bl_exp_q;
  assign burst_order_o = bo_q;

endmodule

// File: rtl/ddr2_cmd_seq_chk.sv
module ddr2_cmd_seq_chk
  import ddr2_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic [3:0] req_op_i,
  input logic       init_done_o,
  input logic       cke_o,
  input logic       cs_no,
  input logic       ras_no,
  input logic       cas_no,
  input logic       we_no
);

  logic [3:0] pins;
  assign pins = {cs_no, ras_no, cas_no, we_no};

  a_r3_no_accept_in_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> !req_ready_o);

  a_r2_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  a_r2_cke_low_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_done_o && !cke_o) |-> pins == 4'b1111);

  a_r4_read_on_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_op_i == OP_RD) |=> (cke_o && pins == 4'b0101));

  a_r12_pd_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_op_i == OP_PD) |=> (!cke_o && pins == 4'b1111));

  // refresh spacing at default timing leaves the following cycle idle
  a_r11_ref_then_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done_o && cke_o && pins == 4'b0001) |=> pins == 4'b0111);

endmodule

bind ddr2_cmd_seq ddr2_cmd_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .req_op_i   (req_op_i),
  .init_done_o(init_done_o),
  .cke_o      (cke_o),
  .cs_no      (cs_no),
  .ras_no     (ras_no),
  .cas_no     (cas_no),
  .we_no      (we_no)
);

// File: tb/ddr2_cmd_seq_bench.sv
`timescale 1ns/1ps
module ddr2_cmd_seq_bench;

  localparam int INIT_C  = 200;  // 2000 ns at 10 ns
  localparam int TRCD_C  = 2;
  localparam int TRP_C   = 2;
  localparam int TRFC_C  = 11;
  localparam int TMOD_C  = 2;
  localparam int TXSNR_C = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_op = '0;
  logic [1:0]  req_bank = '0;
  logic [13:0] req_addr = '0;
  logic [10:0] req_col = '0;
  logic        req_flag = 1'b0;
  logic        init_done, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [13:0] a;
  logic [3:0]  rd_lat, wr_lat;
  logic [7:0]  burst_len;
  logic        burst_order;
  wire  [3:0]  pins = {cs_n, ras_n, cas_n, we_n};

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr2_cmd_seq #(.INIT_NS(2000)) u_ddr2_cmd_seq (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_bank_i(req_bank), .req_addr_i(req_addr), .req_col_i(req_col),
    .req_flag_i(req_flag), .init_done_o(init_done), .cke_o(cke), .cs_no(cs_n),
    .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n), .ba_o(ba), .a_o(a),
    .rd_lat_o(rd_lat), .wr_lat_o(wr_lat), .burst_len_o(burst_len), .burst_order_o(burst_order)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  bank;
    logic [13:0] addr;
    logic [10:0] col;
    logic        fl;
    logic [3:0]  cmd;
    logic [1:0]  exp_ba;
    logic [13:0] exp_a;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd1, 2'd0, 14'h0032, 11'h000, 1'b0, 4'b0000, 2'd0, 14'h0032}, // R4 R7 CL3 BL4
    '{4'd1, 2'd1, 14'h0010, 11'h000, 1'b0, 4'b0000, 2'd1, 14'h0010}, // R4 R7 AL2
    '{4'd2, 2'd1, 14'h1ABC, 11'h000, 1'b0, 4'b0011, 2'd1, 14'h1ABC}, // R4
    '{4'd3, 2'd1, 14'h0000, 11'h5A5, 1'b1, 4'b0101, 2'd1, 14'h0DA5}, // R5
    '{4'd4, 2'd1, 14'h0000, 11'h123, 1'b0, 4'b0100, 2'd1, 14'h0123}, // R5
    '{4'd5, 2'd1, 14'h3FFF, 11'h7FF, 1'b0, 4'b0010, 2'd1, 14'h0000}, // R6
    '{4'd5, 2'd0, 14'h0000, 11'h000, 1'b1, 4'b0010, 2'd0, 14'h0400}, // R6
    '{4'd6, 2'd0, 14'h0000, 11'h000, 1'b0, 4'b0001, 2'd0, 14'h0000}  // R4
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // present a request, wait for acceptance, return the cycle its command shows on the pins
  task automatic do_req(input logic [3:0] op, input int b, input int ad, input int col,
                        input logic fl, output int t);
    req_valid = 1'b1; req_op = op; req_bank = 2'(b); req_addr = 14'(ad);
    req_col = 11'(col); req_flag = fl;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    t = cyc;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0, t1, t2, lowc, nopc, badc, rdyc;
    repeat (3) @(negedge clk);
    chk(cke == 1'b0, "R1 cke", cke, 0);
    chk(pins == 4'b1111, "R1 pins", pins, 4'b1111);
    chk(req_ready == 1'b0 && init_done == 1'b0, "R1 ready/done", {req_ready, init_done}, 0);

    // request held during power-up
    req_valid = 1'b1; req_op = 4'd2; req_bank = 2'd0; req_addr = 14'h0055;
    rst_ni = 1'b1;
    lowc = 0; rdyc = 0; badc = 0;
    while (cke === 1'b0 && lowc < 100) begin
      lowc++;
      if (pins != 4'b1111) badc++;
      if (req_ready) rdyc++;
      @(negedge clk);
    end
    chk(lowc == 10, "R2 cke-low cycles", lowc, 10);
    nopc = 0;
    while (!init_done && nopc < 1000) begin
      nopc++;
      if (pins != 4'b0111 || !cke) badc++;
      if (req_ready) rdyc++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(nopc == INIT_C, "R2 NOP cycles", nopc, INIT_C);
    chk(badc == 0, "R2 power-up pin pattern", badc, 0);
    chk(rdyc == 0, "R3 ready during power-up", rdyc, 0);
    chk(pins == 4'b0111 && cke, "R3 held request not issued", pins, 4'b0111);
    @(negedge clk);
    chk(pins == 4'b0111 && cke && ba == 0 && a == 0, "R14 idle NOP", {pins, a}, 4'b0111 << 14);
    chk(init_done == 1'b1, "R2 done stays", init_done, 1);

    // vector table
    for (int i = 0; i < 8; i++) begin
      do_req(VECS[i].op, VECS[i].bank, VECS[i].addr, VECS[i].col, VECS[i].fl, t0);
      chk(pins == VECS[i].cmd && cke, $sformatf("R4 vec %0d cmd", i), pins, VECS[i].cmd);
      chk(a == VECS[i].exp_a, $sformatf("R5 R6 vec %0d addr", i), a, VECS[i].exp_a);
      chk(ba == VECS[i].exp_ba, $sformatf("R4 vec %0d bank", i), ba, VECS[i].exp_ba);
    end
    chk(rd_lat == 4'd5, "R7 read latency", rd_lat, 5);
    chk(wr_lat == 4'd4, "R7 write latency", wr_lat, 4);
    chk(burst_len == 8'd4 && burst_order == 1'b0, "R7 burst", {burst_len, burst_order}, 8);

    // R8 mode load to bank 2, then R11 tMOD spacing
    do_req(4'd1, 2, 14'h007F, 0, 1'b0, t1);
    chk(pins == 4'b0000 && ba == 2'd2, "R8 mode load issued", {pins, ba}, 2);
    do_req(4'd2, 0, 14'h0005, 0, 1'b0, t2);
    chk(t2 - t1 == TMOD_C, "R11 tMOD gap", t2 - t1, TMOD_C);
    chk(rd_lat == 4'd5 && wr_lat == 4'd4 && burst_len == 8'd4 && burst_order == 1'b0,
        "R8 shadows unchanged", {rd_lat, wr_lat}, 8'h54);

    // R9 tRCD same bank, other bank free
    do_req(4'd3, 0, 0, 11'h010, 1'b0, t1);
    chk(t1 - t2 == TRCD_C, "R9 tRCD gap", t1 - t2, TRCD_C);
    do_req(4'd2, 2, 14'h0077, 0, 1'b0, t2);
    do_req(4'd4, 0, 0, 11'h020, 1'b0, t1);
    chk(t1 - t2 == 1, "R9 other bank not delayed", t1 - t2, 1);

    // R10 tRP
    do_req(4'd5, 0, 0, 0, 1'b0, t1);
    do_req(4'd2, 0, 14'h0100, 0, 1'b0, t2);
    chk(t2 - t1 == TRP_C, "R10 tRP gap", t2 - t1, TRP_C);
    do_req(4'd5, 2, 0, 0, 1'b0, t1);
    do_req(4'd2, 3, 14'h0200, 0, 1'b0, t2);
    chk(t2 - t1 == 1, "R10 other bank not delayed", t2 - t1, 1);
    do_req(4'd5, 0, 0, 0, 1'b1, t1);
    do_req(4'd2, 1, 14'h0300, 0, 1'b0, t2);
    chk(t2 - t1 == TRP_C, "R10 precharge-all gap", t2 - t1, TRP_C);

    // R11 tRFC
    repeat (3) @(negedge clk);
    do_req(4'd6, 0, 0, 0, 1'b0, t1);
    do_req(4'd2, 2, 14'h0400, 0, 1'b0, t2);
    chk(t2 - t1 == TRFC_C, "R11 tRFC gap", t2 - t1, TRFC_C);

    // R12 power-down
    do_req(4'd7, 0, 0, 0, 1'b0, t1);
    chk(!cke && pins == 4'b1111, "R12 power-down entry", {cke, pins}, 4'b1111);
    @(negedge clk);
    chk(cke && pins == 4'b0111, "R12 power-down release", {cke, pins}, 5'b10111);

    // R14 undefined operation code
    do_req(4'd12, 3, 14'h3FFF, 11'h7FF, 1'b1, t1);
    chk(cke && pins == 4'b0111 && a == 0 && ba == 0, "R14 undefined op", {pins, a}, 4'b0111 << 14);

    // R13 self-refresh (banks need precharge spacing done)
    repeat (3) @(negedge clk);
    do_req(4'd8, 0, 0, 0, 1'b0, t1);
    chk(!cke && pins == 4'b0001, "R13 self-refresh entry", {cke, pins}, 4'b0001);
    badc = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (cke || pins != 4'b1111) badc++;
    end
    chk(badc == 0, "R13 self-refresh hold", badc, 0);
    do_req(4'd8, 0, 0, 0, 1'b0, t1);
    chk(!cke && pins == 4'b1111, "R13 repeated self-refresh request", {cke, pins}, 4'b1111);
    t0 = cyc;
    do_req(4'd2, 1, 14'h0011, 0, 1'b0, t2);
    chk(t2 - t0 == TXSNR_C + 1, "R13 exit spacing", t2 - t0, TXSNR_C + 1);
    chk(cke && pins == 4'b0011, "R13 command after exit", {cke, pins}, 5'b10011);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule